// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external asynchronous static RAM of 256K words by 16 bits. The host gives it one word-sized request at a time, a read or a write with a per-byte enable. The block turns each request into a cycle on the memory pins: chip select, write enable, output enable and two active-low byte-lane strobes. It keeps each phase open for a whole number of clock cycles, chosen so that the memory's minimum strobe widths, access times and bus-release windows are met.

All memory timing figures are parameters in nanoseconds, together with the clock period. Each phase lasts the timing figure divided by the period, rounded up, and never less than one cycle. The data bus is split into an output word, an input word and a drive enable, so that the pad ring can build the tristate buffer. The controller raises the drive enable only inside a write strobe, and only after the memory has had time to release the bus.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is low and after it, chip select, write enable, output enable and both lane strobes are high (inactive), the drive enable is low, `req_ready` is high and `rd_valid` is low. Reset is asynchronous and ends any cycle at once.
- R2: A read keeps chip select low, output enable low and write enable high for exactly N_RD cycles. N_RD is the largest of ceil(T_RC/CLK), ceil(T_AA/CLK) and ceil(T_OE/CLK), with a minimum of 1, and is 1 at the defaults.
- R3: Read data is sampled on the clock edge that ends the read phase. `rd_valid` is high for exactly one cycle, the first idle cycle after that edge, with `rd_data` valid. Bits of a lane whose enable is 0 read as zero.
- R4: A write keeps chip select low, write enable low and output enable high for exactly N_WR cycles. N_WR is the larger of ceil(T_WP/CLK) and ceil(T_WHZ/CLK)+ceil(T_DW/CLK), and is 2 at the defaults.
- R5: The drive enable is high only while write enable and chip select are low. It stays low in the first ceil(T_WHZ/CLK) cycles of the write strobe and stays high for the remaining N_WR-ceil(T_WHZ/CLK) strobe cycles. It never rises during a read.
- R6: Request byte-enable bit 0 maps to the low-lane strobe (data bits 7:0) and bit 1 to the high-lane strobe (bits 15:8). A lane strobe is low only while chip select is low and its enable is 1. A lane with enable 0 is left unchanged by a write.
- R7: A write that directly follows a read is preceded by one turnaround cycle. In that cycle chip select is high and the drive enable is low. A write that follows a write, or the first write after reset, gets no turnaround cycle.
- R8: `req_ready` is high only in the idle state. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the next cycle.
- R9: The memory address equals the accepted 18-bit request address, and is stable, for as long as chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0 |
| req_ready | output | 1 | Controller idle, request can be taken |
| rd_data | output | 16 | Captured read word |
| rd_valid | output | 1 | One-cycle read-data strobe |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low-lane strobe, active low |
| mem_ub_n | output | 1 | High-lane strobe, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_en | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
The main function is driven with a table of writes and reads against a behavioural memory model. The sequences mix read-after-write, write-after-read, read-after-read and write-after-write, because only write-after-read may insert the turnaround cycle. Writes are issued with full-word, low-lane-only, high-lane-only and no-lane enables, followed by full-word read-back, which tells lane mapping errors apart from whole-word errors. Reads are issued with single-lane enables to show that unselected bits are zeroed. An address at the top of the range checks that no address bit is lost. A reset asserted in the middle of a write shows that the pins return to idle at once.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int AW        = 18,
  parameter int DW        = 16,
  parameter int CLK_NS    = 10,
  parameter int T_RC_NS   = 10,
  parameter int T_AA_NS   = 10,
  parameter int T_OE_NS   = 5,
  parameter int T_WP_NS   = 7,
  parameter int T_DW_NS   = 5,
  parameter int T_WHZ_NS  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          req_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_en,
  input  logic [DW-1:0] mem_dq_i
);
  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int LANE  = DW / 2;
  localparam int C_RC  = to_cyc(T_RC_NS);
  localparam int C_AA  = to_cyc(T_AA_NS);
  localparam int C_OE  = to_cyc(T_OE_NS);
  localparam int C_WP  = to_cyc(T_WP_NS);
  localparam int N_WHZ = to_cyc(T_WHZ_NS);
  localparam int N_DRV = to_cyc(T_DW_NS);
  localparam int N_RA  = (C_RC > C_AA) ? C_RC : C_AA;
  localparam int N_RD  = (N_RA > C_OE) ? N_RA : C_OE;
  localparam int N_WR  = (C_WP > N_WHZ + N_DRV) ? C_WP : N_WHZ + N_DRV;
  localparam int N_MX  = (N_RD > N_WR) ? N_RD : N_WR;
  localparam int CW    = $clog2(N_MX + 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_TURN, S_WRITE} state_t;

  state_t          st;
  logic [CW-1:0]   cnt;
  logic            last_rd;
  logic [AW-1:0]   a_q;
  logic [DW-1:0]   d_q;
  logic [1:0]      be_q;
  logic [DW-1:0]   lane_mask;

  assign lane_mask = {{LANE{be_q[1]}}, {LANE{be_q[0]}}};
  assign req_ready = (st == S_IDLE);
  assign mem_cs_n  = !(st == S_READ || st == S_WRITE);
  assign mem_we_n  = (st != S_WRITE);
  assign mem_oe_n  = (st != S_READ);
  assign mem_lb_n  = mem_cs_n || !be_q[0];
  assign mem_ub_n  = mem_cs_n || !be_q[1];
  assign mem_addr  = a_q;
  assign mem_dq_o  = d_q;
  assign mem_dq_en = (st == S_WRITE) && (cnt <= CW'(N_WR - 1 - N_WHZ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      last_rd  <= 1'b0;
      a_q      <= '0;
      d_q      <= '0;
      be_q     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q     <= req_addr;
          d_q     <= req_wdata;
          be_q    <= req_be;
          last_rd <= !req_write;
          if (!req_write) begin
            st  <= S_READ;
            cnt <= CW'(N_RD - 1);
          end else if (last_rd) begin
            st  <= S_TURN;
          end else begin
            st  <= S_WRITE;
            cnt <= CW'(N_WR - 1);
          end
        end
        S_TURN: begin
          st  <= S_WRITE;
          cnt <= CW'(N_WR - 1);
        end
        S_READ: if (cnt == '0) begin
          st       <= S_IDLE;
          rd_valid <= 1'b1;
          rd_data  <= mem_dq_i & lane_mask;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: if (cnt == '0) st <= S_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  // R5
  drive_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_en |-> (!mem_we_n && !mem_cs_n));
  // R4
  oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  // R2
  read_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n));
  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_dq_en));
  // R6
  lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_lb_n && mem_ub_n));
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  // R5
  drive_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (N_WHZ == 0 || !mem_dq_en));
endmodule

// File: tb/test_sram_cycle_ctrl.sv
module test_sram_cycle_ctrl;
  localparam int CLK_NS = 10;

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int N_RD  = to_cyc(10);
  localparam int N_WHZ = to_cyc(5);
  localparam int N_WR  = (to_cyc(7) > N_WHZ + to_cyc(5)) ? to_cyc(7) : N_WHZ + to_cyc(5);

  typedef struct packed {
    logic        wr;
    logic [17:0] a;
    logic [15:0] d;
    logic [1:0]  be;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 18'h00010, 16'h1234, 2'b11},
    '{1'b1, 18'h3FF20, 16'hABCD, 2'b11},
    '{1'b0, 18'h00010, 16'h1234, 2'b11},
    '{1'b1, 18'h00010, 16'hFF77, 2'b01},
    '{1'b0, 18'h00010, 16'h1277, 2'b11},
    '{1'b1, 18'h00010, 16'h99EE, 2'b10},
    '{1'b0, 18'h00010, 16'h9977, 2'b11},
    '{1'b0, 18'h00010, 16'h0077, 2'b01},
    '{1'b0, 18'h00010, 16'h9900, 2'b10},
    '{1'b0, 18'h3FF20, 16'hABCD, 2'b11},
    '{1'b1, 18'h00030, 16'h0000, 2'b11},
    '{1'b1, 18'h00030, 16'hFFFF, 2'b00},
    '{1'b0, 18'h00030, 16'h0000, 2'b11},
    '{1'b1, 18'h3FF20, 16'h5555, 2'b11}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_en;
  logic [15:0] rd_data, mem_dq_o, mem_dq_i;
  logic [17:0] mem_addr;
  logic [15:0] mem [0:255];
  int checks = 0, fails = 0;
  bit done = 1'b0, prev_rd = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  sram_cycle_ctrl i_sram_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_o(mem_dq_o), .mem_dq_en(mem_dq_en), .mem_dq_i(mem_dq_i)
  );

  always_comb begin
    if (!mem_cs_n && !mem_oe_n && mem_we_n)
      mem_dq_i = {mem_ub_n ? 8'hA5 : mem[mem_addr[7:0]][15:8],
                  mem_lb_n ? 8'h5A : mem[mem_addr[7:0]][7:0]};
    else
      mem_dq_i = 16'hDEAD;
  end

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n && mem_dq_en) begin
      if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
      if (!mem_ub_n) mem[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v);
    int busy = 0, cs_cnt = 0, we_cnt = 0, drv_cnt = 0, first_drv = -1;
    int bad_addr = 0, bad_lane = 0, bad_oe = 0, bad_drv = 0, bad_rd = 0, bad_vld = 0;
    bit first_hi = 1'b0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_addr = v.a; req_wdata = v.d; req_be = v.be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8 ready drops after accept", 32'(req_ready), 0);
    while (!req_ready && busy < 50) begin
      if (busy == 0) first_hi = mem_cs_n && !mem_dq_en;
      if (!mem_cs_n) begin
        cs_cnt++;
        if (mem_addr != v.a) bad_addr++;
        if (mem_lb_n != !v.be[0] || mem_ub_n != !v.be[1]) bad_lane++;
      end
      if (!mem_we_n) begin
        if (mem_dq_en && first_drv < 0) first_drv = we_cnt;
        we_cnt++;
      end
      if (mem_dq_en) drv_cnt++;
      if (mem_dq_en && mem_we_n) bad_drv++;
      if (v.wr && !mem_oe_n) bad_oe++;
      if (!v.wr && !mem_cs_n && (!mem_we_n || mem_oe_n)) bad_rd++;
      if (rd_valid) bad_vld++;
      busy++;
      @(negedge clk);
    end
    check(bad_addr == 0, "R9 address during cycle", 32'(bad_addr), 0);
    check(bad_lane == 0, "R6 lane strobes", 32'(bad_lane), 0);
    check(bad_drv == 0, "R5 drive outside strobe", 32'(bad_drv), 0);
    check(bad_vld == 0, "R3 no valid while busy", 32'(bad_vld), 0);
    if (v.wr) begin
      check(busy == N_WR + (prev_rd ? 1 : 0), "R7 write length incl. turnaround", 32'(busy), 32'(N_WR + (prev_rd ? 1 : 0)));
      if (prev_rd) check(first_hi, "R7 turnaround cycle idle", 32'(first_hi), 1);
      check(we_cnt == N_WR && cs_cnt == N_WR, "R4 write strobe width", 32'(we_cnt), 32'(N_WR));
      check(bad_oe == 0, "R4 output enable high in write", 32'(bad_oe), 0);
      check(first_drv == N_WHZ, "R5 first driven strobe cycle", 32'(first_drv), 32'(N_WHZ));
      check(drv_cnt == N_WR - N_WHZ, "R5 driven cycles", 32'(drv_cnt), 32'(N_WR - N_WHZ));
    end else begin
      check(busy == N_RD && cs_cnt == N_RD, "R2 read length", 32'(busy), 32'(N_RD));
      check(bad_rd == 0 && we_cnt == 0, "R2 read strobe levels", 32'(bad_rd), 0);
      check(drv_cnt == 0, "R5 no drive in read", 32'(drv_cnt), 0);
      check(rd_valid, "R3 valid after read", 32'(rd_valid), 1);
      check(rd_data == v.d, "R3 R6 read data", 32'(rd_data), 32'(v.d));
      @(negedge clk);
      check(!rd_valid, "R3 valid is one cycle", 32'(rd_valid), 0);
    end
    prev_rd = !v.wr;
  endtask

  task automatic check_idle(input string req);
    check(mem_cs_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n,
          req, {27'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 32'h1F);
    check(!mem_dq_en && req_ready && !rd_valid, req,
          {29'd0, mem_dq_en, req_ready, rd_valid}, 32'h2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check_idle("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");
    for (int i = 0; i < NV; i++) run_op(VECS[i]);
    // R1: reset in the middle of a write
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00040; req_wdata = 16'hCAFE; req_be = 2'b11;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!mem_we_n, "R4 write started", 32'(mem_we_n), 0);
    rst_n = 1'b0;
    #1;
    check_idle("R1 reset mid write");
    @(negedge clk);
    rst_n = 1'b1;
    prev_rd = 1'b0;
    @(negedge clk);
    run_op('{1'b0, 18'h00040, 16'h0000, 2'b11});
    run_op('{1'b1, 18'h00040, 16'h0F0F, 2'b11});
    run_op('{1'b0, 18'h00040, 16'h0F0F, 2'b11});
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule